// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Engine

This block turns one host request at a time into a single strobed cycle on a raw NAND flash pin bus. A request is a command byte, an address byte, a data word to write, or a data word to read. The engine drives the latch-enable strobes and the active-low write and read strobes, enables the I/O drivers for the write-type cycles, and returns the word it read. Every cycle has three phases: setup, strobe and hold. Each phase takes its length from its own 3-bit input, counted in system clock cycles.

The host waits for `busy` to be low and raises `reqValid` for one cycle. The engine latches the request, the three timing values and the bus width at that edge. `busy` stays high until the hold phase ends, and `done` pulses in the first idle cycle. The chip enable follows a host control bit directly. No request is taken while the global enable is low. Command sequencing, error correction and the ready/busy pin are handled outside this block.

Top module: `nand_strobe_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `cle`, `ale` and `ioOe` are 0, and `weN` and `reN` are 1.
- R2: A request is accepted on a rising clock edge where `reqValid`=1, `enable`=1 and `busy`=0. A setup phase of exactly `tSetup` cycles then follows, with `busy` high and both strobes high. A `tSetup` of 0 makes the strobe start in the first cycle after acceptance.
- R3: The active strobe (`weN` for write-type cycles, `reN` for reads) is low for exactly `tStrobe`+1 consecutive cycles. It is high at all other times.
- R4: A hold phase of exactly `tHold`+1 cycles follows the strobe, with `busy` still high. In the first cycle after the hold phase, `busy` is 0 and `done` is 1 for that single cycle.
- R5: `reqKind` encoding: 0 = command (`cle` high), 1 = address (`ale` high), 2 = data write, 3 = data read. Neither latch enable is high for kinds 2 and 3. A latch enable is high for the whole setup, strobe and hold span.
- R6: `ioOe` is 1 for the whole busy span of kinds 0, 1 and 2, and 0 for reads and while idle. While `ioOe` is 1, `ioOut` equals the latched `reqData` when the latched width is 16-bit. When the width is 8-bit, `ioOut` carries bits 7:0 with the upper bits zero.
- R7: A read captures `ioIn` at the clock edge where `reN` rises, which is the edge that ends the last strobe cycle. `rdData` holds this value afterwards. In 8-bit mode, bits 15:8 of `rdData` are zero.
- R8: `ceN` equals `ceCtl` at all times: 0 drives chip enable low and 1 drives it high.
- R9: While `enable`=0, `reqValid` is ignored and no cycle starts.
- R10: A `reqValid` raised while `busy`=1 is ignored. The current cycle's kind, data, phase lengths and outputs are unchanged.
- R11: `busWide` (0 = 8-bit, 1 = 16-bit) and the three timing inputs are taken at acceptance. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Global enable; no cycle starts while 0 |
| busWide | input | 1 | Bus width select: 0 = 8-bit, 1 = 16-bit |
| ceCtl | input | 1 | Chip-enable control copied to `ceN` |
| tSetup | input | 3 | Setup phase length in cycles |
| tStrobe | input | 3 | Strobe low width minus one |
| tHold | input | 3 | Hold phase length minus one |
| reqValid | input | 1 | Request strobe, one cycle |
| reqKind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| reqData | input | 16 | Command, address or write data |
| busy | output | 1 | High from acceptance to end of hold |
| done | output | 1 | One-cycle pulse after hold |
| rdData | output | 16 | Last word captured by a read |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Active-low write strobe |
| reN | output | 1 | Active-low read strobe |
| ceN | output | 1 | Active-low chip enable |
| ioOut | output | 16 | I/O bus drive value |
| ioOe | output | 1 | I/O output driver enable |
| ioIn | input | 16 | I/O bus sampled value |

## Verification
A wrong phase counter or phase register shows up at the pins within the same cycle. A strobe edge lands one cycle early or late, or `busy`/`done` moves against the computed cycle count. Checking every cycle of every request catches this at the first bad cycle. A capture taken at the wrong edge is seen when the read's `done` arrives. The bench drives the I/O bus with the true word only during the last strobe cycle, so any other capture edge returns the wrong word. A lost latch of kind, width or timing shows up as soon as the bench disturbs those inputs in mid-cycle.

// File: rtl/nse_pkg.sv
package nse_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_WR   = 2'd2,
    KIND_RD   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request data and width
    logic capture;  // sample the I/O bus (read strobe rising)
    logic cleOn;
    logic aleOn;
    logic weOn;
    logic reOn;
    logic driveOn;
  } strobe_t;

endpackage

// File: rtl/nse_ctrl.sv
module nse_ctrl
  import nse_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          reqValid,
  input  logic [1:0]    reqKind,
  input  logic [TW-1:0] tSetup,
  input  logic [TW-1:0] tStrobe,
  input  logic [TW-1:0] tHold,
  output strobe_t       ctl,
  output logic          busy,
  output logic          done
);

  localparam logic [TW-1:0] ONE = TW'(1);

  phase_e        phase;
  kind_e         kindQ;
  logic [TW-1:0] cnt;
  logic [TW-1:0] tSetupQ;
  logic [TW-1:0] tStrobeQ;
  logic [TW-1:0] tHoldQ;
  logic          doneQ;
  logic          accept;
  logic          strobeLast;

  assign accept     = reqValid && enable && (phase == PH_IDLE);
  assign strobeLast = (phase == PH_STROBE) && (cnt == tStrobeQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      kindQ    <= KIND_CMD;
      cnt      <= '0;
      tSetupQ  <= '0;
      tStrobeQ <= '0;
      tHoldQ   <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (accept) begin
            kindQ    <= kind_e'(reqKind);
            tSetupQ  <= tSetup;
            tStrobeQ <= tStrobe;
            tHoldQ   <= tHold;
            cnt      <= '0;
            phase    <= (tSetup == '0) ? PH_STROBE : PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt == tSetupQ - ONE) begin
            cnt   <= '0;
            phase <= PH_STROBE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_STROBE: begin
          if (strobeLast) begin
            cnt   <= '0;
            phase <= PH_HOLD;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        PH_HOLD: begin
          if (cnt == tHoldQ) begin
            cnt   <= '0;
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.load    = accept;
    ctl.capture = strobeLast && (kindQ == KIND_RD);
    ctl.cleOn   = (phase != PH_IDLE) && (kindQ == KIND_CMD);
    ctl.aleOn   = (phase != PH_IDLE) && (kindQ == KIND_ADDR);
    ctl.weOn    = (phase == PH_STROBE) && (kindQ != KIND_RD);
    ctl.reOn    = (phase == PH_STROBE) && (kindQ == KIND_RD);
    ctl.driveOn = (phase != PH_IDLE) && (kindQ != KIND_RD);
  end

  assign busy = (phase != PH_IDLE);
  assign done = doneQ;

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && phase == PH_IDLE) |=> (phase == PH_IDLE));

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid) |=> ($stable(kindQ) && $stable(tStrobeQ) && $stable(tHoldQ)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (phase == PH_IDLE && $past(phase) == PH_HOLD));

  // R3
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> (cnt <= tStrobeQ));

endmodule

// File: rtl/nse_datapath.sv
module nse_datapath
  import nse_pkg::*;
#(
  parameter int IO_W     = 16,
  parameter int NARROW_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         ctl,
  input  logic [IO_W-1:0] reqData,
  input  logic            busWide,
  input  logic            ceCtl,
  input  logic [IO_W-1:0] ioIn,
  output logic            cle,
  output logic            ale,
  output logic            weN,
  output logic            reN,
  output logic            ceN,
  output logic [IO_W-1:0] ioOut,
  output logic            ioOe,
  output logic [IO_W-1:0] rdData
);

  localparam int UPPER_W = IO_W - NARROW_W;
  localparam logic [IO_W-1:0] NARROW_MASK = {{UPPER_W{1'b0}}, {NARROW_W{1'b1}}};

  logic [IO_W-1:0] dataQ;
  logic [IO_W-1:0] rdQ;
  logic            wideQ;
  logic [IO_W-1:0] widthMask;

  generate
    if (UPPER_W > 0) begin : g_dual_width
      assign widthMask = wideQ ? {IO_W{1'b1}} : NARROW_MASK;
    end else begin : g_single_width
      assign widthMask = {IO_W{1'b1}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      wideQ <= 1'b0;
    end else if (ctl.load) begin
      dataQ <= reqData;
      wideQ <= busWide;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctl.capture) begin
      rdQ <= ioIn & widthMask;
    end
  end

  assign cle    = ctl.cleOn;
  assign ale    = ctl.aleOn;
  assign weN    = ~ctl.weOn;
  assign reN    = ~ctl.reOn;
  assign ceN    = ceCtl;
  assign ioOe   = ctl.driveOn;
  assign ioOut  = dataQ & widthMask;
  assign rdData = rdQ;

  // R6
  bus_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    ioOe |-> reN);

  // R5
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cle && ale));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

endmodule

// File: rtl/nand_strobe_engine.sv
module nand_strobe_engine
  import nse_pkg::*;
#(
  parameter int IO_W     = 16,
  parameter int NARROW_W = 8,
  parameter int TW       = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            busWide,
  input  logic            ceCtl,
  input  logic [TW-1:0]   tSetup,
  input  logic [TW-1:0]   tStrobe,
  input  logic [TW-1:0]   tHold,
  input  logic            reqValid,
  input  logic [1:0]      reqKind,
  input  logic [IO_W-1:0] reqData,
  output logic            busy,
  output logic            done,
  output logic [IO_W-1:0] rdData,
  output logic            cle,
  output logic            ale,
  output logic            weN,
  output logic            reN,
  output logic            ceN,
  output logic [IO_W-1:0] ioOut,
  output logic            ioOe,
  input  logic [IO_W-1:0] ioIn
);

  strobe_t ctl;

  nse_ctrl #(.TW(TW)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .tSetup   (tSetup),
    .tStrobe  (tStrobe),
    .tHold    (tHold),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  nse_datapath #(.IO_W(IO_W), .NARROW_W(NARROW_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqData (reqData),
    .busWide (busWide),
    .ceCtl   (ceCtl),
    .ioIn    (ioIn),
    .cle     (cle),
    .ale     (ale),
    .weN     (weN),
    .reN     (reN),
    .ceN     (ceN),
    .ioOut   (ioOut),
    .ioOe    (ioOe),
    .rdData  (rdData)
  );

endmodule

// File: tb/nand_strobe_engine_tb.sv
module nand_strobe_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        busWide = 1'b0;
  logic        ceCtl = 1'b1;
  logic [2:0]  tSetup = '0;
  logic [2:0]  tStrobe = '0;
  logic [2:0]  tHold = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqKind = '0;
  logic [15:0] reqData = '0;
  logic [15:0] ioIn = '0;
  logic        busy, done, cle, ale, weN, reN, ceN, ioOe;
  logic [15:0] rdData, ioOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nand_strobe_engine dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .busWide(busWide), .ceCtl(ceCtl),
    .tSetup(tSetup), .tStrobe(tStrobe), .tHold(tHold),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .busy(busy), .done(done), .rdData(rdData), .cle(cle), .ale(ale),
    .weN(weN), .reN(reN), .ceN(ceN), .ioOut(ioOut), .ioOe(ioOe), .ioIn(ioIn)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Issues one request from a negedge and checks every cycle until done.
  task automatic runOp(int ts, int tw, int th, int kind, bit wide,
                       logic [15:0] data, bit disturb);
    int lastStrobe = ts + tw + 1;
    int total = ts + tw + th + 3;
    logic [15:0] pat = data ^ 16'h5A3C;
    logic [15:0] mask = wide ? 16'hFFFF : 16'h00FF;
    tSetup = 3'(ts); tStrobe = 3'(tw); tHold = 3'(th);
    busWide = wide; reqKind = 2'(kind); reqData = data; reqValid = 1'b1;
    ioIn = ~pat;
    @(posedge clk); #1 reqValid = 1'b0;
    for (int i = 1; i <= total; i++) begin
      bit setupP, strobeP, inOp, endP;
      string req;
      @(negedge clk);
      setupP  = (i <= ts);
      strobeP = (i > ts) && (i <= lastStrobe);
      endP    = (i == total);
      inOp    = !endP;
      req     = setupP ? "R2" : (strobeP ? "R3" : "R4");
      chk(req, "busy", 16'(busy), 16'(inOp));
      chk("R4", "done", 16'(done), 16'(endP));
      chk("R5", "cle", 16'(cle), 16'(inOp && kind == 0));
      chk("R5", "ale", 16'(ale), 16'(inOp && kind == 1));
      chk(req, "weN", 16'(weN), 16'(!(strobeP && kind != 3)));
      chk(req, "reN", 16'(reN), 16'(!(strobeP && kind == 3)));
      chk("R6", "ioOe", 16'(ioOe), 16'(inOp && kind != 3));
      if (inOp && kind != 3) chk(disturb ? "R11" : "R6", "ioOut", ioOut, data & mask);
      if (endP && kind == 3) chk(disturb ? "R11" : "R7", "rdData", rdData, pat & mask);
      ioIn = (i == lastStrobe) ? pat : ~pat;
      if (disturb && i == 1) begin
        // R10 / R11: a second request and changed settings mid-cycle
        reqValid = 1'b1; reqKind = 2'(kind ^ 1); reqData = ~data;
        tSetup = ~3'(ts); tStrobe = ~3'(tw); tHold = ~3'(th); busWide = !wide;
      end
      if (disturb && i == 2) reqValid = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", 16'(busy), 16'h0);
    chk("R1", "done", 16'(done), 16'h0);
    chk("R1", "cle", 16'(cle), 16'h0);
    chk("R1", "ale", 16'(ale), 16'h0);
    chk("R1", "weN", 16'(weN), 16'h1);
    chk("R1", "reN", 16'(reN), 16'h1);
    chk("R1", "ioOe", 16'(ioOe), 16'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: requests ignored while disabled
    tStrobe = 3'd1; reqKind = 2'd0; reqValid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9", "busy", 16'(busy), 16'h0);
      chk("R9", "weN", 16'(weN), 16'h1);
      chk("R9", "cle", 16'(cle), 16'h0);
    end
    reqValid = 1'b0;
    enable = 1'b1;

    // R8: chip enable follows control bit
    ceCtl = 1'b0; #1 chk("R8", "ceN", 16'(ceN), 16'h0);
    ceCtl = 1'b1; #1 chk("R8", "ceN", 16'(ceN), 16'h1);
    ceCtl = 1'b0;
    @(negedge clk);

    // R5 / R6 / R7: every kind in both widths
    for (int k = 0; k < 4; k++)
      for (int w = 0; w < 2; w++)
        runOp(1, 2, 1, k, w[0], 16'hC3A5 + 16'(k * 16'h1111), 1'b0);

    // R2 / R3 / R4 / R10 / R11: full timing sweep
    for (int ts = 0; ts < 8; ts++)
      for (int tw = 0; tw < 8; tw++)
        for (int th = 0; th < 8; th++)
          runOp(ts, tw, th, (ts + tw + th) % 4, 1'((ts ^ th) & 1),
                16'h1234 + 16'(ts * 16'h0111) + 16'(tw * 16'h1010) + 16'(th * 16'h0303),
                ((ts + tw) % 3) == 0);

    finished = 1;
    summary();
  end

endmodule